// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Write Master

This block is the write side of a master on a 32-bit bus where address and data share the same wires. A local client hands it one request: a target address, a three-bit access size code, a DMA flag and up to eight 32-bit words of write data. The block then runs the whole bus transfer on its own. The first bus cycle is an address phase that puts the size code and the address on the shared lines. One or more data phases follow, each carrying one 32-bit beat.

The first data beat can be held back by a programmable number of internal wait cycles. Every beat is also stretched for as long as the target keeps its active-low ready input high. The block drives these strobes on separate outputs:

- frame
- read/write, held at write
- bus start
- chip select
- per-lane write enables
- an active-high DMA acknowledge

When the last beat completes, every strobe returns to its idle level and a one-cycle done pulse goes back to the client. No new request is taken while a transfer is in flight.

Top module: `mux_wr_master`

## Requirements
- R1: Idle levels. After reset and between transfers the outputs are: `frame_n`=1, `rdwr`=1, `we_n`=4'b1111, `bs_n`=1, `cs_n`=1, `dack`=0, `ad_out`=0, `done`=0 and `req_ready`=1.
- R2: Accept and address phase. A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. The next cycle is the address phase, in which `ad_out` = {size[2:0], 3'b000, addr[25:0]}: the size is in bits 31..29 and the address is in bits 25..0.
- R3: Bus start and chip select. `bs_n` is low for exactly one cycle, the address phase. `cs_n` and `rdwr` stay low from the address phase through the last cycle of the final data beat.
- R4: Beat count and data order. Any size code with bit 2 set moves 8 beats (32 bytes). Code 3'b011 moves 2 beats. Codes 3'b000, 3'b001 and 3'b010 move 1 beat. Beat k drives `req_wdata[32k+31:32k]` as it was captured at accept.
- R5: Internal waits. The first data beat is held for `cfg_iwait` extra cycles, and `rdy_n` is ignored during those cycles. Later beats get no internal wait.
- R6: External ready. `rdy_n` is active-low. Once the internal waits have run out, a beat completes at the first edge where `rdy_n` is sampled low. While `rdy_n` is high the beat is held unchanged.
- R7: Frame. `frame_n` is low during the address phase and every non-final data beat. It is high for the whole final beat.
- R8: Write enables. Lane i of `we_n` covers `ad_out[8i+7:8i]`, and the enables are active-low. `we_n` is 4'b1111 in the address phase. In data phases the enabled lanes are set by size code and address:
  - byte (000): lane addr[1:0] only
  - word (001): lanes 1:0 if addr[1]=0, lanes 3:2 if addr[1]=1
  - every other code: all four lanes
- R9: DMA acknowledge. `dack` is active-high. It equals the `req_dma` value captured at accept through the address and data phases, and is 0 otherwise.
- R10: End of transfer. `done` is high for exactly the one cycle after the final beat completes, and all strobes are at idle levels in that cycle. `req_ready` is low from the address phase through the final beat, and `req_valid` is ignored in that span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client request strobe |
| req_ready | output | 1 | Master idle, able to accept |
| req_size | input | 3 | Access size code |
| req_addr | input | 26 | Target address |
| req_dma | input | 1 | Transfer is a DMA acknowledge cycle |
| req_wdata | input | 256 | Write beats, beat k in bits 32k+31:32k |
| cfg_iwait | input | 4 | Internal wait cycles before the first beat |
| rdy_n | input | 1 | Target ready, active-low |
| ad_out | output | 32 | Shared address/data lines |
| frame_n | output | 1 | Frame, active-low |
| rdwr | output | 1 | Read/write, 0 = write |
| bs_n | output | 1 | Bus start, active-low |
| cs_n | output | 1 | Chip select, active-low |
| we_n | output | 4 | Per-lane write enables, active-low |
| dack | output | 1 | DMA acknowledge, active-high |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties check, on every cycle, the following:
- bus start lasts a single cycle and never coincides with a write enable;
- a beat cannot advance while internal waits remain or while ready is high;
- the beat index stays within the count for the size;
- the captured request stays frozen while busy;
- the done pulse lasts one cycle.

The exact address-phase word, the data word on each beat, the lane pattern for each size and address, the frame release on the final beat and the cycle count of each beat under given wait and stall settings depend on the values requested. Only the bench's directed transfers, compared cycle by cycle against independently computed expectations, show those.

// File: rtl/mux_wr_pkg.sv
package mux_wr_pkg;

    localparam int BUS_W     = 32;
    localparam int ADDR_W    = 26;
    localparam int SIZE_W    = 3;
    localparam int LANES     = BUS_W / 8;
    localparam int MAX_BEATS = 8;
    localparam int BIDX_W    = $clog2(MAX_BEATS);
    localparam int PAD_W     = BUS_W - SIZE_W - ADDR_W;

    localparam logic [SIZE_W-1:0] SZ_BYTE = 3'b000;
    localparam logic [SIZE_W-1:0] SZ_WORD = 3'b001;
    localparam logic [SIZE_W-1:0] SZ_QUAD = 3'b011;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic [ADDR_W-1:0] addr;
        logic              dma;
    } xfer_hdr_t;

    typedef struct packed {
        logic [BUS_W-1:0] ad;
        logic             frame_n;
        logic             rdwr;
        logic [LANES-1:0] we_n;
        logic             bs_n;
        logic             cs_n;
        logic             dack;
    } pins_t;

    localparam pins_t PINS_IDLE = '{ad: '0, frame_n: 1'b1, rdwr: 1'b1,
                                    we_n: '1, bs_n: 1'b1, cs_n: 1'b1,
                                    dack: 1'b0};

    // Index of the final beat for a size code.
    function automatic logic [BIDX_W-1:0] last_beat_of(input logic [SIZE_W-1:0] sz);
        if (sz[SIZE_W-1])
            return BIDX_W'(MAX_BEATS - 1);
        else if (sz == SZ_QUAD)
            return BIDX_W'(1);
        else
            return '0;
    endfunction

    // Active-high byte-lane enables from size code and low address bits.
    function automatic logic [LANES-1:0] lanes_of(input logic [SIZE_W-1:0] sz,
                                                  input logic [1:0] lo);
        logic [LANES-1:0] en;
        if (sz == SZ_BYTE)
            en = LANES'(1) << lo;
        else if (sz == SZ_WORD)
            en = lo[1] ? 4'b1100 : 4'b0011;
        else
            en = '1;
        return en;
    endfunction

    function automatic logic [BUS_W-1:0] addr_word(input xfer_hdr_t h);
        return {h.size, {PAD_W{1'b0}}, h.addr};
    endfunction

endpackage

// File: rtl/mux_wr_decode.sv
module mux_wr_decode
    import mux_wr_pkg::*;
(
    input  logic [SIZE_W-1:0] size,
    input  logic [1:0]        addr_lo,
    output logic [BIDX_W-1:0] last_idx,
    output logic [LANES-1:0]  lane_en
);
    always_comb begin
        last_idx = last_beat_of(size);
        lane_en  = lanes_of(size, addr_lo);
    end
endmodule

// File: rtl/mux_wr_waitctr.sv
module mux_wr_waitctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R5: internal waits count down one per cycle once loaded
    a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/mux_wr_seq.sv
module mux_wr_seq
    import mux_wr_pkg::*;
#(
    parameter int IWAIT_W = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  xfer_hdr_t                  req_hdr,
    input  logic [MAX_BEATS*BUS_W-1:0] req_wdata,
    input  logic [IWAIT_W-1:0]         cfg_iwait,
    input  logic                       rdy_n,
    output phase_e                     phase,
    output xfer_hdr_t                  hdr,
    output logic [BIDX_W-1:0]          beat,
    output logic [BIDX_W-1:0]          last_idx,
    output logic [LANES-1:0]           lane_en,
    output logic [BUS_W-1:0]           beat_word,
    output logic                       done
);
    phase_e                     phase_q;
    xfer_hdr_t                  hdr_q;
    logic [MAX_BEATS*BUS_W-1:0] data_q;
    logic [BIDX_W-1:0]          beat_q;
    logic                       done_q;
    logic                       waits_gone;
    logic                       beat_ends;

    mux_wr_decode u_decode (
        .size     (hdr_q.size),
        .addr_lo  (hdr_q.addr[1:0]),
        .last_idx (last_idx),
        .lane_en  (lane_en)
    );

    mux_wr_waitctr #(.CNT_W(IWAIT_W)) u_waitctr (
        .clk      (clk),
        .rst      (rst),
        .load     (phase_q == PH_ADDR),
        .load_val (cfg_iwait),
        .expired  (waits_gone)
    );

    assign beat_ends = (phase_q == PH_DATA) && waits_gone && !rdy_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            hdr_q   <= '0;
            data_q  <= '0;
            beat_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (req_valid) begin
                        hdr_q   <= req_hdr;
                        data_q  <= req_wdata;
                        phase_q <= PH_ADDR;
                    end
                end
                PH_ADDR: begin
                    beat_q  <= '0;
                    phase_q <= PH_DATA;
                end
                PH_DATA: begin
                    if (beat_ends) begin
                        if (beat_q == last_idx) begin
                            phase_q <= PH_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase     = phase_q;
    assign hdr       = hdr_q;
    assign beat      = beat_q;
    assign beat_word = data_q[beat_q*BUS_W +: BUS_W];
    assign done      = done_q;

    // R5: no beat progress while internal waits remain
    a_r5_hold_internal: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DATA && !waits_gone) |=> (phase_q == PH_DATA && $stable(beat_q)));

    // R6: ready high stretches the current beat
    a_r6_stretch: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DATA && rdy_n) |=> (phase_q == PH_DATA && $stable(beat_q)));

    // R4: beat index never runs past the size's final beat
    a_r4_beat_bound: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DATA) |-> (beat_q <= last_idx));

    // R10: captured request frozen while busy
    a_r10_hold_request: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE) |=> ($stable(hdr_q) && $stable(data_q)));

    // R10: done lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
endmodule

// File: rtl/mux_wr_drive.sv
module mux_wr_drive
    import mux_wr_pkg::*;
(
    input  phase_e            phase,
    input  xfer_hdr_t         hdr,
    input  logic [BIDX_W-1:0] beat,
    input  logic [BIDX_W-1:0] last_idx,
    input  logic [LANES-1:0]  lane_en,
    input  logic [BUS_W-1:0]  beat_word,
    output pins_t             pins
);
    always_comb begin
        pins = PINS_IDLE;
        unique case (phase)
            PH_ADDR: begin
                pins.ad      = addr_word(hdr);
                pins.frame_n = 1'b0;
                pins.rdwr    = 1'b0;
                pins.bs_n    = 1'b0;
                pins.cs_n    = 1'b0;
                pins.dack    = hdr.dma;
            end
            PH_DATA: begin
                pins.ad      = beat_word;
                pins.frame_n = (beat == last_idx);
                pins.rdwr    = 1'b0;
                pins.we_n    = ~lane_en;
                pins.cs_n    = 1'b0;
                pins.dack    = hdr.dma;
            end
            default: pins = PINS_IDLE;
        endcase
    end
endmodule

// File: rtl/mux_wr_master.sv
module mux_wr_master
    import mux_wr_pkg::*;
#(
    parameter int IWAIT_W = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [SIZE_W-1:0]          req_size,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       req_dma,
    input  logic [MAX_BEATS*BUS_W-1:0] req_wdata,
    input  logic [IWAIT_W-1:0]         cfg_iwait,
    input  logic                       rdy_n,
    output logic [BUS_W-1:0]           ad_out,
    output logic                       frame_n,
    output logic                       rdwr,
    output logic                       bs_n,
    output logic                       cs_n,
    output logic [LANES-1:0]           we_n,
    output logic                       dack,
    output logic                       done
);
    phase_e            phase;
    xfer_hdr_t         hdr;
    xfer_hdr_t         req_hdr;
    logic [BIDX_W-1:0] beat;
    logic [BIDX_W-1:0] last_idx;
    logic [LANES-1:0]  lane_en;
    logic [BUS_W-1:0]  beat_word;
    pins_t             pins;

    assign req_hdr = '{size: req_size, addr: req_addr, dma: req_dma};

    mux_wr_seq #(.IWAIT_W(IWAIT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_hdr   (req_hdr),
        .req_wdata (req_wdata),
        .cfg_iwait (cfg_iwait),
        .rdy_n     (rdy_n),
        .phase     (phase),
        .hdr       (hdr),
        .beat      (beat),
        .last_idx  (last_idx),
        .lane_en   (lane_en),
        .beat_word (beat_word),
        .done      (done)
    );

    mux_wr_drive u_drive (
        .phase     (phase),
        .hdr       (hdr),
        .beat      (beat),
        .last_idx  (last_idx),
        .lane_en   (lane_en),
        .beat_word (beat_word),
        .pins      (pins)
    );

    assign req_ready = (phase == PH_IDLE);
    assign ad_out    = pins.ad;
    assign frame_n   = pins.frame_n;
    assign rdwr      = pins.rdwr;
    assign bs_n      = pins.bs_n;
    assign cs_n      = pins.cs_n;
    assign we_n      = pins.we_n;
    assign dack      = pins.dack;

    // R3: bus start is a single-cycle pulse
    a_r3_bs_single: assert property (@(posedge clk) disable iff (rst)
        !bs_n |=> bs_n);

    // R3: chip select and frame accompany bus start
    a_r3_bs_framed: assert property (@(posedge clk) disable iff (rst)
        !bs_n |-> (!cs_n && !frame_n && !rdwr));

    // R8: no write enable during the address phase
    a_r8_no_we_addr: assert property (@(posedge clk) disable iff (rst)
        !bs_n |-> (&we_n));

    // R1: idle master drives inactive strobes
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (cs_n && frame_n && bs_n && (&we_n) && !dack));

    // R10: done comes with idle strobes
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (req_ready && cs_n && frame_n));
endmodule

// File: tb/mux_wr_master_bench.sv
module mux_wr_master_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic         req_ready;
    logic [2:0]   req_size;
    logic [25:0]  req_addr;
    logic         req_dma;
    logic [255:0] req_wdata;
    logic [3:0]   cfg_iwait;
    logic         rdy_n;
    logic [31:0]  ad_out;
    logic         frame_n, rdwr, bs_n, cs_n, dack, done;
    logic [3:0]   we_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mux_wr_master u_mux_wr_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_size(req_size), .req_addr(req_addr), .req_dma(req_dma),
        .req_wdata(req_wdata), .cfg_iwait(cfg_iwait), .rdy_n(rdy_n),
        .ad_out(ad_out), .frame_n(frame_n), .rdwr(rdwr), .bs_n(bs_n),
        .cs_n(cs_n), .we_n(we_n), .dack(dack), .done(done)
    );

    localparam logic [40:0] IDLE_PINS = {32'h0, 1'b1, 1'b1, 4'hF, 1'b1, 1'b1, 1'b0};

    function automatic logic [40:0] actual_pins();
        return {ad_out, frame_n, rdwr, we_n, bs_n, cs_n, dack};
    endfunction

    function automatic logic [40:0] mk(input logic [31:0] ad, input logic fr,
                                       input logic [3:0] we, input logic bs,
                                       input logic da);
        return {ad, fr, 1'b0, we, bs, 1'b0, da};
    endfunction

    function automatic logic [3:0] want_we_n(input logic [2:0] sz, input logic [1:0] lo);
        logic [3:0] en;
        case (sz)
            3'b000:  en = 4'b0001 << lo;
            3'b001:  en = lo[1] ? 4'b1100 : 4'b0011;
            default: en = 4'b1111;
        endcase
        return ~en;
    endfunction

    function automatic logic [31:0] word_k(input logic [25:0] a, input int k);
        return 32'hC3A50000 ^ (32'(k) * 32'h01030507) ^ {6'h0, a};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_pins(input string req, input logic [40:0] exp);
        chk(actual_pins() === exp, req, 64'(actual_pins()), 64'(exp));
    endtask

    // One write transfer, compared cycle by cycle.
    task automatic run_xfer(input logic [2:0] sz, input logic [25:0] a, input int iw,
                            input int stall, input logic dma, input bit poke_busy);
        int nb;
        nb = sz[2] ? 8 : (sz == 3'b011) ? 2 : 1;
        @(negedge clk);
        req_size  = sz;
        req_addr  = a;
        req_dma   = dma;
        cfg_iwait = 4'(iw);
        for (int k = 0; k < 8; k++) req_wdata[32*k +: 32] = word_k(a, k);
        req_valid = 1'b1;
        rdy_n     = 1'b0;
        chk(req_ready === 1'b1, "R10 ready before accept", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = poke_busy;
        if (poke_busy) begin
            req_addr  = 26'h3FFFFFF;
            req_size  = 3'b000;
            req_wdata = '1;
        end
        // address phase: R2 word, R3 bus start, R9 dack
        chk_pins("R2 address phase", mk({sz, 3'b000, a}, 1'b0, 4'hF, 1'b0, dma));
        chk(req_ready === 1'b0, "R10 busy in address phase", 64'(req_ready), 64'd0);
        rdy_n = 1'b0;
        for (int b = 0; b < nb; b++) begin
            int nw;
            int tot;
            nw  = (b == 0) ? iw : 0;
            tot = nw + stall + 1;
            for (int c = 0; c < tot; c++) begin
                string tag;
                @(negedge clk);
                if (c < nw)                tag = "R5 internal wait";
                else if (c < nw + stall)   tag = "R6 ready stall";
                else if (b == nb - 1)      tag = "R7 final beat";
                else                       tag = "R4 data beat";
                chk_pins(tag, mk(word_k(a, b), (b == nb - 1), want_we_n(sz, a[1:0]), 1'b1, dma));
                if (poke_busy)
                    chk(req_ready === 1'b0, "R10 busy ignores request", 64'(req_ready), 64'd0);
                if (c < nw)              rdy_n = 1'b0;  // ignored (R5)
                else if (c < nw + stall) rdy_n = 1'b1;
                else                     rdy_n = 1'b0;
                if (b == nb - 1 && c == tot - 1) req_valid = 1'b0;
            end
        end
        @(negedge clk);
        rdy_n = 1'b1;
        chk(done === 1'b1, "R10 done pulse", 64'(done), 64'd1);
        chk_pins("R1 idle after transfer", IDLE_PINS);
        chk(req_ready === 1'b1, "R10 ready after transfer", 64'(req_ready), 64'd1);
        @(negedge clk);
        chk(done === 1'b0, "R10 done single cycle", 64'(done), 64'd0);
        chk(bs_n === 1'b1, "R10 no stale accept", 64'(bs_n), 64'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1; req_valid = 1'b0; req_size = '0; req_addr = '0; req_dma = 1'b0;
        req_wdata = '0; cfg_iwait = '0; rdy_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_pins("R1 reset levels", IDLE_PINS);
        chk(done === 1'b0, "R1 done low", 64'(done), 64'd0);
        chk(req_ready === 1'b1, "R1 ready high", 64'(req_ready), 64'd1);
    endtask

    task automatic t_byte_lanes();
        run_xfer(3'b000, 26'h0012340, 0, 0, 1'b0, 1'b0);  // R8 lane 0
        run_xfer(3'b000, 26'h0012343, 0, 1, 1'b0, 1'b0);  // R8 lane 3
    endtask

    task automatic t_word_upper();
        run_xfer(3'b001, 26'h2ABCDE6, 1, 0, 1'b0, 1'b0);  // R8 upper half
    endtask

    task automatic t_long_waits_dma();
        run_xfer(3'b010, 26'h1555554, 2, 1, 1'b1, 1'b0);  // R5 R6 R9
    endtask

    task automatic t_quad();
        run_xfer(3'b011, 26'h0000108, 0, 2, 1'b0, 1'b0);  // R4 two beats
    endtask

    task automatic t_burst_busy();
        run_xfer(3'b100, 26'h3F00020, 1, 1, 1'b0, 1'b1);  // R4 eight beats, R10
    endtask

    task automatic t_burst_alt_code();
        run_xfer(3'b111, 26'h0ABC000, 3, 0, 1'b1, 1'b0);  // R4 code 1xx, R9
    endtask

    initial begin
        t_reset();
        t_byte_lanes();
        t_word_upper();
        t_long_waits_dma();
        t_quad();
        t_burst_busy();
        t_burst_alt_code();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule